// File: doc/BRIEF.md
# Hall-Sensor Commutation Decoder

This block turns three digitised rotor-position bits from Hall sensors into six-step commands for a three-phase bridge that drives a brushless motor. For each phase it produces a high-side enable and a low-side enable. In every valid rotor position exactly one phase sources current through its high-side switch and one other phase sinks it through its low-side switch. A direction select reverses rotation by inverting the sensor code before the commutation table.

Motor power is set by chopping the low-side switch with an externally generated PWM gate. The high-side switch of the active step stays fully on. Three things can hold the low side off. A current-limit request ends the low-side on time for the rest of the present PWM period. A restraint-protection trip holds every low-side switch off for as long as it is asserted. A stop request turns the whole bridge off.

The Hall bits are asynchronous and pass through a synchroniser before they are decoded. When the step changes, the block first puts every switch off for one clock, so no phase can conduct through both of its switches.

Top module: `hall_commutator`

## Requirements
- R1: With `dir_rev` low, the code on `hall_in` (bit 2 = sensor A, bit 1 = sensor B, bit 0 = sensor C) selects the sourcing phase on `hi_en` and the sinking phase on `lo_en`, with phase 1 on bit 0, as follows. 101 gives hi phase 2 and lo phase 1. 100 gives hi 3 and lo 1. 110 gives hi 3 and lo 2. 010 gives hi 1 and lo 2. 011 gives hi 1 and lo 3. 001 gives hi 2 and lo 3.
- R2: With `dir_rev` high, the block applies the R1 table to the bitwise inverse of `hall_in`. For example, 010 then gives hi phase 2 and lo phase 1.
- R3: Hall codes 000 and 111 drive all six enables low.
- R4: While `stop_req` is high, all six enables are low from the next clock edge on. A value of 1 means stop, so a line pulled high selects stop; the same holds for `dir_rev`, where 1 means reverse.
- R5: A low-side enable is high only if `pwm_gate` was high at the clock edge that set it. The high-side enable of the step is not affected by `pwm_gate`.
- R6: A high `ilim_cut` forces `lo_en` low from the next edge on. It stays low, even after `ilim_cut` falls, until an edge at which `pwm_gate` is low has been seen.
- R7: While `lock_trip` is high, `lo_en` is zero from the next edge on, and `hi_en` keeps its step value.
- R8: When the decoded step changes from one valid step to a different one, the outputs are all low for exactly one cycle before the new step appears.
- R9: `hi_en` and `lo_en` each have at most one bit set, and no phase has both of its enables high.
- R10: A change on `hall_in` reaches the outputs at the third rising edge: two synchroniser stages plus the output register. `stop_req`, `dir_rev`, `pwm_gate`, `ilim_cut` and `lock_trip` act at the first edge.
- R11: While reset is applied, and for the two edges after it is released, all enables are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| hall_in | input | 3 | Digitised Hall sensor bits, asynchronous |
| dir_rev | input | 1 | 1 = reverse rotation, 0 = forward |
| stop_req | input | 1 | 1 = stop (bridge off), 0 = run |
| pwm_gate | input | 1 | Low-side chopping gate, 1 = on |
| ilim_cut | input | 1 | Current-limit request, ends the low-side on time for the period |
| lock_trip | input | 1 | Restraint protection trip, forces every low side off |
| hi_en | output | 3 | High-side enables, bit 0 = phase 1 |
| lo_en | output | 3 | Low-side enables, bit 0 = phase 1 |

## Verification
The commutation table is swept over all eight Hall codes in both directions with the gate held on. This separates a wrong phase assignment from a wrong direction inversion, and it confirms that 000 and 111 give all-off. A step change is then followed edge by edge: the old step holds for two edges, the outputs are all off at the third, and the new step appears at the fourth, which shows both the synchroniser latency and the dead cycle. Pulses on the gate, current limit, trip and stop inputs are each applied to a running step. These show that only the low side is chopped, that a current-limit cut outlasts its request until the gate falls, and that the high side keeps its value through a trip.

// File: rtl/hall_commutator_pkg.sv
package hall_commutator_pkg;
  localparam int unsigned PHASES = 3;

  typedef struct packed {
    logic [PHASES-1:0] hi;
    logic [PHASES-1:0] lo;
  } drive_t;

  localparam drive_t DRIVE_OFF = '{hi: '0, lo: '0};
endpackage

// File: rtl/hall_input_sync.sv
module hall_input_sync #(
  parameter int unsigned WIDTH  = 3,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);
  logic [STAGES-1:0][WIDTH-1:0] chain_q;
  logic [STAGES-1:0][WIDTH-1:0] chain_d;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        assign chain_d[g] = async_in;
      end else begin : g_next
        assign chain_d[g] = chain_q[g-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign sync_out = chain_q[STAGES-1];
endmodule

// File: rtl/commut_step_decode.sv
module commut_step_decode
  import hall_commutator_pkg::*;
(
  input  logic [2:0] code,
  input  logic       dir_rev,
  output drive_t     pattern
);
  logic [2:0] eff_code;

  always_comb begin
    eff_code = dir_rev ? ~code : code;
    pattern  = DRIVE_OFF;
    unique case (eff_code)
      3'b101: pattern = '{hi: 3'b010, lo: 3'b001};
      3'b100: pattern = '{hi: 3'b100, lo: 3'b001};
      3'b110: pattern = '{hi: 3'b100, lo: 3'b010};
      3'b010: pattern = '{hi: 3'b001, lo: 3'b010};
      3'b011: pattern = '{hi: 3'b001, lo: 3'b100};
      3'b001: pattern = '{hi: 3'b010, lo: 3'b100};
      default: pattern = DRIVE_OFF;
    endcase
  end
endmodule

// File: rtl/lowside_chop.sv
module lowside_chop (
  input  logic clk,
  input  logic rst_n,
  input  logic pwm_gate,
  input  logic ilim_cut,
  input  logic lock_trip,
  output logic lo_allow
);
  logic cut_q;
  logic cut_d;

  always_comb begin
    cut_d    = pwm_gate & (cut_q | ilim_cut);
    lo_allow = pwm_gate & ~ilim_cut & ~cut_q & ~lock_trip;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cut_q <= 1'b0;
    else        cut_q <= cut_d;
  end
endmodule

// File: rtl/hall_commutator.sv
module hall_commutator
  import hall_commutator_pkg::*;
#(
  parameter int unsigned SYNC_STAGES  = 2,
  parameter int unsigned RESET_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] hall_in,
  input  logic       dir_rev,
  input  logic       stop_req,
  input  logic       pwm_gate,
  input  logic       ilim_cut,
  input  logic       lock_trip,
  output logic [2:0] hi_en,
  output logic [2:0] lo_en
);
  localparam int unsigned HALL_W = 3;

  logic [RESET_STAGES-1:0] rst_pipe_q;
  logic                    rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[RESET_STAGES-2:0], 1'b1};
  end
  assign rst_int_n = rst_pipe_q[RESET_STAGES-1];

  logic [HALL_W-1:0] hall_sync;
  drive_t            dec_pat;
  logic              lo_allow;

  hall_input_sync #(.WIDTH(HALL_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .async_in (hall_in),
    .sync_out (hall_sync)
  );

  commut_step_decode u_dec (
    .code    (hall_sync),
    .dir_rev (dir_rev),
    .pattern (dec_pat)
  );

  lowside_chop u_chop (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .pwm_gate  (pwm_gate),
    .ilim_cut  (ilim_cut),
    .lock_trip (lock_trip),
    .lo_allow  (lo_allow)
  );

  drive_t     step_q, step_d, target;
  logic       step_en;
  logic [2:0] lo_q, lo_d;

  always_comb begin
    target = stop_req ? DRIVE_OFF : dec_pat;
    if (target == step_q)
      step_d = step_q;
    else if (step_q != DRIVE_OFF && target != DRIVE_OFF)
      step_d = DRIVE_OFF;
    else
      step_d = target;
    step_en = (step_d != step_q);
    lo_d    = step_d.lo & {3{lo_allow}};
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      step_q <= DRIVE_OFF;
    end else if (step_en) begin
      step_q <= step_d;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) lo_q <= '0;
    else            lo_q <= lo_d;
  end

  assign hi_en = step_q.hi;
  assign lo_en = lo_q;
endmodule

// File: rtl/hall_commutator_chk.sv
module hall_commutator_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       stop_req,
  input logic       pwm_gate,
  input logic       lock_trip,
  input logic [2:0] hi_en,
  input logic [2:0] lo_en
);
  assert_no_shoot_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (hi_en & lo_en) == 3'b000);

  assert_onehot_hi_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hi_en));

  assert_onehot_lo_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lo_en));

  assert_stop_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
    stop_req |=> (hi_en == 3'b000 && lo_en == 3'b000));

  assert_lock_lo_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
    lock_trip |=> (lo_en == 3'b000));

  assert_pwm_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (lo_en != 3'b000) |-> $past(pwm_gate));

  assert_dead_hi_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ((hi_en != 3'b000) && ($past(hi_en) != 3'b000)) |-> (hi_en == $past(hi_en)));

  assert_dead_lo_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ((lo_en != 3'b000) && ($past(lo_en) != 3'b000)) |-> (lo_en == $past(lo_en)));
endmodule

bind hall_commutator hall_commutator_chk chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .stop_req  (stop_req),
  .pwm_gate  (pwm_gate),
  .lock_trip (lock_trip),
  .hi_en     (hi_en),
  .lo_en     (lo_en)
);

// File: tb/hall_commutator_tb_top.sv
module hall_commutator_tb_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [2:0] hall_in;
  logic       dir_rev, stop_req, pwm_gate, ilim_cut, lock_trip;
  logic [2:0] hi_en, lo_en;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 1'b0;

  always #5 clk = ~clk;

  hall_commutator dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .hall_in   (hall_in),
    .dir_rev   (dir_rev),
    .stop_req  (stop_req),
    .pwm_gate  (pwm_gate),
    .ilim_cut  (ilim_cut),
    .lock_trip (lock_trip),
    .hi_en     (hi_en),
    .lo_en     (lo_en)
  );

  // Expected {hi, lo}; phase n on bit n-1, reverse inverts the code first.
  function automatic logic [5:0] model(input logic [2:0] code, input logic rev);
    logic [2:0] c;
    c = rev ? ~code : code;
    case (c)
      3'b101:  return {3'b010, 3'b001};
      3'b100:  return {3'b100, 3'b001};
      3'b110:  return {3'b100, 3'b010};
      3'b010:  return {3'b001, 3'b010};
      3'b011:  return {3'b001, 3'b100};
      3'b001:  return {3'b010, 3'b100};
      default: return 6'b000000;
    endcase
  endfunction

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input logic [5:0] exp_v);
    n_checks++;
    if ({hi_en, lo_en} !== exp_v) begin
      n_fails++;
      $display("FAIL %s: actual hi=%b lo=%b expected hi=%b lo=%b",
               req, hi_en, lo_en, exp_v[5:3], exp_v[2:0]);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++;
    n_fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; hall_in = 3'b101; dir_rev = 1'b0; stop_req = 1'b0;
    pwm_gate = 1'b1; ilim_cut = 1'b0; lock_trip = 1'b0;
    repeat (3) tick();
    check("R11 reset", 6'b0);
    rst_n = 1'b1;
    tick();
    check("R11 reset release", 6'b0);
    repeat (6) tick();

    // R1 R2 R3: sweep all codes in both directions
    for (int d = 0; d < 2; d++) begin
      for (int c = 0; c < 8; c++) begin
        hall_in = c[2:0];
        dir_rev = d[0];
        repeat (6) tick();
        check(d ? "R2 reverse table" : "R1 forward table", model(c[2:0], d[0]));
        if (c == 0 || c == 7) check("R3 invalid code", 6'b0);
      end
    end

    // R8 R10: dead cycle on a step change 101 -> 100, forward
    dir_rev = 1'b0; hall_in = 3'b101;
    repeat (6) tick();
    check("R1 start step", {3'b010, 3'b001});
    hall_in = 3'b100;
    tick(); tick();
    check("R10 old step holds through sync", {3'b010, 3'b001});
    tick();
    check("R8 dead cycle", 6'b0);
    tick();
    check("R8 new step after dead cycle", {3'b100, 3'b001});
    tick();
    check("R8 new step stays", {3'b100, 3'b001});

    // R5: gate low chops the low side only
    pwm_gate = 1'b0;
    tick();
    check("R5 gate low", {3'b100, 3'b000});
    pwm_gate = 1'b1;
    tick();
    check("R5 gate high", {3'b100, 3'b001});

    // R6: current limit holds the low side off until the gate falls
    ilim_cut = 1'b1;
    tick();
    check("R6 cut takes effect", {3'b100, 3'b000});
    ilim_cut = 1'b0;
    tick();
    check("R6 cut outlasts request", {3'b100, 3'b000});
    tick();
    check("R6 cut held in period", {3'b100, 3'b000});
    pwm_gate = 1'b0;
    tick();
    pwm_gate = 1'b1;
    tick();
    check("R6 restored next period", {3'b100, 3'b001});

    // R7: trip forces low sides off, high side kept
    lock_trip = 1'b1;
    tick();
    check("R7 trip", {3'b100, 3'b000});
    tick();
    check("R7 trip held", {3'b100, 3'b000});
    lock_trip = 1'b0;
    tick();
    check("R7 released", {3'b100, 3'b001});

    // R4 R10: stop acts at the next edge; run resumes directly
    stop_req = 1'b1;
    tick();
    check("R4 stop", 6'b0);
    hall_in = 3'b010;
    repeat (4) tick();
    check("R4 stop holds", 6'b0);
    stop_req = 1'b0;
    tick();
    check("R10 run resumes", {3'b001, 3'b010});

    // R2 R10: direction change goes through one dead cycle
    dir_rev = 1'b1;
    tick();
    check("R8 dead cycle on direction", 6'b0);
    tick();
    check("R2 reversed step", {3'b010, 3'b001});

    finish_run();
  end
endmodule